// File: doc/BRIEF.md
# Translation Buffer with Block Entries

This block turns a 48-bit virtual address into a 32-bit real address. It holds 96 fully associative entries for ordinary 4 KB pages. Beside them sit four block entries. Each block entry maps one aligned region whose size is a power of two, from 4 KB up to 16 MB. A lookup searches both sets in parallel. The offset inside the page (the low 12 address bits) passes through unchanged. Alongside the address, the block returns a permission field that it does not decode.

Software loads page entries through one write port. A pointer picks the slot to replace, and it moves round-robin after each page write. Block entries are written by explicit index. The size of a block is given as a code `s` in the range 0 to 12, which means a region of 2^(12+s) bytes. A single purge input drops every valid entry. Each lookup result is registered and appears in the cycle after the request. It shows either a hit, with an address and permissions, or a miss.

Top module: `tlbx_top`

## Requirements
- R1: While reset is held and after it, `res_valid`, `res_hit` and `res_miss` are low and `res_paddr` is zero. No entry is valid after reset, so the first lookup misses.
- R2: A request with `lk_valid` high in one cycle gives `res_valid` high in the next cycle, with exactly one of `res_hit` and `res_miss` set. A cycle with no request gives all three low in the next cycle.
- R3: A page hit gives `res_paddr = {stored real page number, lk_vaddr[11:0]}` and `res_perm` equal to the stored permission field.
- R4: A miss sets `res_miss` and drives `res_paddr` and `res_perm` to zero.
- R5: A block entry with size code `s` matches when the virtual page numbers agree above bit `s`. Its real page number keeps the stored base bits above bit `s` and takes the lookup's virtual page bits below bit `s`. Stored base bits below the alignment are ignored.
- R6: When a block entry and a page entry both match, the block entry supplies the translation and permissions.
- R7: Writing a block entry at index 0 to 3 replaces only that entry. The region it covered before no longer translates through it, and the other block entries are unchanged.
- R8: Each page write fills the slot under the round-robin pointer. The pointer then steps by one and wraps from 95 to 0. After 96 distinct page writes, a 97th write displaces the first of them.
- R9: A purge makes every page entry and every block entry invalid at the next clock edge. A page write or block write in the same cycle as a purge is dropped.
- R10: A lookup in the same cycle as a write sees the contents from before that write.
- R11: A block size code above 12 is treated as 12, which is a 16 MB region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| fill_page | input | 1 | Write a page entry at the round-robin slot |
| fill_block | input | 1 | Write a block entry at `fill_blk_idx` |
| fill_blk_idx | input | 2 | Block entry index |
| fill_vpn | input | 36 | Virtual page number (base page number for a block) |
| fill_ppn | input | 20 | Real page number (base page number for a block) |
| fill_size | input | 4 | Block size code s, region 2^(12+s) bytes |
| fill_perm | input | 4 | Permission field to store |
| purge | input | 1 | Invalidate all entries |
| res_valid | output | 1 | A lookup result is present |
| res_hit | output | 1 | The lookup hit |
| res_miss | output | 1 | The lookup missed |
| res_paddr | output | 32 | Translated real address, zero on a miss |
| res_perm | output | 4 | Permission field of the hit entry, zero on a miss |

## Verification
Page lookups are tried with several different offsets and with neighbouring page numbers. This separates a correct full-width compare from one that checks too few bits or mixes up the page offset.

Block entries are tried at the smallest size, a mid size, the largest size and an oversized code. Lookups are placed just inside and just outside each region. This shows whether the compare mask, the splicing of the real page number and the size clamping are each correct.

Overlapping block and page entries show which one wins. A lookup issued in the same cycle as a write, and a write issued in the same cycle as a purge, show how these events are ordered. Filling all 96 page slots plus one more shows the replacement order.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W        = 48;
  localparam int RA_W        = 32;
  localparam int PG_OFF      = 12;
  localparam int VPN_W       = VA_W - PG_OFF;
  localparam int PPN_W       = RA_W - PG_OFF;
  localparam int MAX_BLK_LOG = 24;
  localparam int MASK_W      = MAX_BLK_LOG - PG_OFF;
  localparam int SZ_W        = $clog2(MASK_W + 1);

  // Size code to a mask of page-number bits that fall inside the block.
  // Codes above MASK_W saturate to the largest block.
  function automatic logic [MASK_W-1:0] size_to_mask(input logic [SZ_W-1:0] sz);
    logic [MASK_W-1:0] m;
    m = '0;
    for (int i = 0; i < MASK_W; i++)
      if (i < int'(sz)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [VPN_W-1:0] widen_mask(input logic [MASK_W-1:0] m);
    return {{(VPN_W-MASK_W){1'b0}}, m};
  endfunction

  // Region compare: only bits outside the mask must agree.
  function automatic logic blk_match(input logic [VPN_W-1:0] vpn,
                                     input logic [VPN_W-1:0] base,
                                     input logic [MASK_W-1:0] m);
    return ((vpn ^ base) & ~widen_mask(m)) == '0;
  endfunction

  // Splice: stored base above the mask, lookup bits inside it.
  function automatic logic [PPN_W-1:0] blk_ppn(input logic [PPN_W-1:0] base_ppn,
                                               input logic [VPN_W-1:0] vpn,
                                               input logic [MASK_W-1:0] m);
    logic [PPN_W-1:0] mw;
    mw = {{(PPN_W-MASK_W){1'b0}}, m};
    return (base_ppn & ~mw) | (vpn[PPN_W-1:0] & mw);
  endfunction
endpackage

// File: rtl/tlbx_page_array.sv
module tlbx_page_array
  import tlbx_pkg::*;
#(
  parameter int N_PAGE = 96,
  parameter int PERM_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      purge,
  input  logic                      wr_en,
  input  logic [VPN_W-1:0]          wr_vpn,
  input  logic [PPN_W-1:0]          wr_ppn,
  input  logic [PERM_W-1:0]         wr_perm,
  input  logic [VPN_W-1:0]          lk_vpn,
  output logic                      hit,
  output logic [PPN_W-1:0]          hit_ppn,
  output logic [PERM_W-1:0]         hit_perm,
  output logic [N_PAGE-1:0]         vld_vec,
  output logic [$clog2(N_PAGE)-1:0] rr_ptr
);
  localparam int PTR_W = $clog2(N_PAGE);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_PAGE - 1);

  logic [N_PAGE-1:0] vld_q;
  logic [VPN_W-1:0]  vpn_q  [N_PAGE];
  logic [PPN_W-1:0]  ppn_q  [N_PAGE];
  logic [PERM_W-1:0] perm_q [N_PAGE];
  logic [PTR_W-1:0]  ptr_q;
  logic [N_PAGE-1:0] hit_vec;
  logic              do_wr;

  assign do_wr = wr_en && !purge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (purge) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[ptr_q]  <= wr_vpn;
      ppn_q[ptr_q]  <= wr_ppn;
      perm_q[ptr_q] <= wr_perm;
    end
  end

  for (genvar gi = 0; gi < N_PAGE; gi++) begin : g_cmp
    assign hit_vec[gi] = vld_q[gi] && (vpn_q[gi] == lk_vpn);
  end

  // Entries are expected to be unique; a one-hot OR mux is enough.
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < N_PAGE; i++) begin
      if (hit_vec[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
  end

  assign hit     = |hit_vec;
  assign vld_vec = vld_q;
  assign rr_ptr  = ptr_q;
endmodule

// File: rtl/tlbx_block_array.sv
module tlbx_block_array
  import tlbx_pkg::*;
#(
  parameter int N_BLK  = 4,
  parameter int PERM_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     purge,
  input  logic                     wr_en,
  input  logic [$clog2(N_BLK)-1:0] wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PPN_W-1:0]         wr_ppn,
  input  logic [SZ_W-1:0]          wr_size,
  input  logic [PERM_W-1:0]        wr_perm,
  input  logic [VPN_W-1:0]         lk_vpn,
  output logic                     hit,
  output logic [PPN_W-1:0]         hit_ppn,
  output logic [PERM_W-1:0]        hit_perm,
  output logic [N_BLK-1:0]         vld_vec
);
  logic [N_BLK-1:0]  vld_q;
  logic [VPN_W-1:0]  base_q [N_BLK];
  logic [PPN_W-1:0]  ppn_q  [N_BLK];
  logic [MASK_W-1:0] mask_q [N_BLK];
  logic [PERM_W-1:0] perm_q [N_BLK];
  logic [N_BLK-1:0]  hit_vec;
  logic              do_wr;

  assign do_wr = wr_en && !purge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld_q <= '0;
    else if (purge)   vld_q <= '0;
    else if (wr_en)   vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      base_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      mask_q[wr_idx] <= size_to_mask(wr_size);
      perm_q[wr_idx] <= wr_perm;
    end
  end

  for (genvar gb = 0; gb < N_BLK; gb++) begin : g_cmp
    assign hit_vec[gb] = vld_q[gb] && blk_match(lk_vpn, base_q[gb], mask_q[gb]);
  end

  // Overlapping blocks: the lowest index is chosen.
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = N_BLK - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_ppn  = blk_ppn(ppn_q[i], lk_vpn, mask_q[i]);
        hit_perm = perm_q[i];
      end
    end
  end

  assign hit     = |hit_vec;
  assign vld_vec = vld_q;
endmodule

// File: rtl/tlbx_result.sv
module tlbx_result
  import tlbx_pkg::*;
#(
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PG_OFF-1:0] lk_off,
  input  logic              page_hit,
  input  logic [PPN_W-1:0]  page_ppn,
  input  logic [PERM_W-1:0] page_perm,
  input  logic              blk_hit,
  input  logic [PPN_W-1:0]  blk_ppn_in,
  input  logic [PERM_W-1:0] blk_perm,
  output logic              sel_block,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic [RA_W-1:0]   res_paddr,
  output logic [PERM_W-1:0] res_perm
);
  logic              any_hit;
  logic [PPN_W-1:0]  pick_ppn;
  logic [PERM_W-1:0] pick_perm;

  assign sel_block = blk_hit;
  assign any_hit   = page_hit || blk_hit;
  assign pick_ppn  = sel_block ? blk_ppn_in : page_ppn;
  assign pick_perm = sel_block ? blk_perm   : page_perm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_paddr <= '0;
      res_perm  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_hit;
      res_miss  <= lk_valid && !any_hit;
      res_paddr <= (lk_valid && any_hit) ? {pick_ppn, lk_off} : '0;
      res_perm  <= (lk_valid && any_hit) ? pick_perm : '0;
    end
  end
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int N_PAGE = 96,
  parameter int N_BLK  = 4,
  parameter int PERM_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic                     fill_page,
  input  logic                     fill_block,
  input  logic [$clog2(N_BLK)-1:0] fill_blk_idx,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic [SZ_W-1:0]          fill_size,
  input  logic [PERM_W-1:0]        fill_perm,
  input  logic                     purge,
  output logic                     res_valid,
  output logic                     res_hit,
  output logic                     res_miss,
  output logic [RA_W-1:0]          res_paddr,
  output logic [PERM_W-1:0]        res_perm
);
  localparam int PTR_W = $clog2(N_PAGE);

  logic [VPN_W-1:0]  lk_vpn;
  logic              page_hit_any, blk_hit_any, sel_block;
  logic [PPN_W-1:0]  page_ppn, blk_ppn_w;
  logic [PERM_W-1:0] page_perm, blk_perm;
  logic [N_PAGE-1:0] page_vld;
  logic [N_BLK-1:0]  blk_vld;
  logic [PTR_W-1:0]  rr_ptr;

  assign lk_vpn = lk_vaddr[VA_W-1:PG_OFF];

  tlbx_page_array #(.N_PAGE(N_PAGE), .PERM_W(PERM_W)) u_pages (
    .clk(clk), .rst_n(rst_n), .purge(purge),
    .wr_en(fill_page), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn), .wr_perm(fill_perm),
    .lk_vpn(lk_vpn), .hit(page_hit_any), .hit_ppn(page_ppn), .hit_perm(page_perm),
    .vld_vec(page_vld), .rr_ptr(rr_ptr)
  );

  tlbx_block_array #(.N_BLK(N_BLK), .PERM_W(PERM_W)) u_blocks (
    .clk(clk), .rst_n(rst_n), .purge(purge),
    .wr_en(fill_block), .wr_idx(fill_blk_idx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .wr_size(fill_size), .wr_perm(fill_perm),
    .lk_vpn(lk_vpn), .hit(blk_hit_any), .hit_ppn(blk_ppn_w), .hit_perm(blk_perm),
    .vld_vec(blk_vld)
  );

  tlbx_result #(.PERM_W(PERM_W)) u_res (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_vaddr[PG_OFF-1:0]),
    .page_hit(page_hit_any), .page_ppn(page_ppn), .page_perm(page_perm),
    .blk_hit(blk_hit_any), .blk_ppn_in(blk_ppn_w), .blk_perm(blk_perm),
    .sel_block(sel_block),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_paddr(res_paddr), .res_perm(res_perm)
  );
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
  import tlbx_pkg::*;
#(
  parameter int N_PAGE = 96,
  parameter int N_BLK  = 4,
  parameter int PERM_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lk_valid,
  input logic                      fill_page,
  input logic                      purge,
  input logic                      res_valid,
  input logic                      res_hit,
  input logic                      res_miss,
  input logic [RA_W-1:0]           res_paddr,
  input logic [PERM_W-1:0]         res_perm,
  input logic [N_PAGE-1:0]         page_vld,
  input logic [N_BLK-1:0]          blk_vld,
  input logic                      blk_hit_any,
  input logic [PPN_W-1:0]          blk_ppn_w,
  input logic [$clog2(N_PAGE)-1:0] rr_ptr
);
  localparam int PTR_W = $clog2(N_PAGE);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit && !res_miss));
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_miss));
  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_paddr == '0 && res_perm == '0));
  // R9
  purge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> (page_vld == '0 && blk_vld == '0));
  // R6
  block_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && blk_hit_any) |=> (res_hit && res_paddr[RA_W-1:PG_OFF] == $past(blk_ppn_w)));
  // R8
  rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_page && !purge) |=>
      rr_ptr == (($past(rr_ptr) == PTR_W'(N_PAGE - 1)) ? '0 : $past(rr_ptr) + 1'b1));
  // R8
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_page && !purge) |=> $stable(rr_ptr));
endmodule

bind tlbx_top tlbx_chk #(.N_PAGE(N_PAGE), .N_BLK(N_BLK), .PERM_W(PERM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_page(fill_page), .purge(purge),
  .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
  .res_paddr(res_paddr), .res_perm(res_perm),
  .page_vld(page_vld), .blk_vld(blk_vld), .blk_hit_any(blk_hit_any),
  .blk_ppn_w(blk_ppn_w), .rr_ptr(rr_ptr)
);

// File: tb/test_tlbx_top.sv
`timescale 1ns/1ps
module test_tlbx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        fill_page = 1'b0, fill_block = 1'b0;
  logic [1:0]  fill_blk_idx = '0;
  logic [35:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [3:0]  fill_size = '0;
  logic [3:0]  fill_perm = '0;
  logic        purge = 1'b0;
  logic        res_valid, res_hit, res_miss;
  logic [31:0] res_paddr;
  logic [3:0]  res_perm;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tlbx_top i_tlbx_top (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_page(fill_page), .fill_block(fill_block), .fill_blk_idx(fill_blk_idx),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_perm(fill_perm),
    .purge(purge), .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
    .res_paddr(res_paddr), .res_perm(res_perm)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Block translation restated with shifts: region of 2**s pages.
  function automatic logic [31:0] exp_blk(input logic [35:0] vpn, input logic [11:0] off,
                                          input logic [19:0] bppn, input int s);
    logic [63:0] p;
    int ss;
    ss = (s > 12) ? 12 : s;
    p = ((64'(bppn) >> ss) << ss) + (64'(vpn) % (64'd1 << ss));
    return {p[19:0], off};
  endfunction

  task automatic lookup(input logic [47:0] va, output logic h, output logic m,
                        output logic [31:0] pa, output logic [3:0] pm);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    h = res_hit; m = res_miss; pa = res_paddr; pm = res_perm;
  endtask

  task automatic expect_hit(input logic [47:0] va, input logic [31:0] epa,
                            input logic [3:0] epm, input string req);
    logic h, m; logic [31:0] pa; logic [3:0] pm;
    lookup(va, h, m, pa, pm);
    check(h && !m, req, {h, m}, 2'b10);
    check(pa == epa && pm == epm, req, {pm, pa}, {epm, epa});
  endtask

  task automatic expect_miss(input logic [47:0] va, input string req);
    logic h, m; logic [31:0] pa; logic [3:0] pm;
    lookup(va, h, m, pa, pm);
    check(m && !h, req, {h, m}, 2'b01);
    check(pa == 0 && pm == 0, req, {pm, pa}, 0);
  endtask

  task automatic put_page(input logic [35:0] vpn, input logic [19:0] ppn, input logic [3:0] pm);
    @(negedge clk);
    fill_page = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = pm;
    @(negedge clk);
    fill_page = 1'b0;
  endtask

  task automatic put_block(input logic [1:0] idx, input logic [35:0] vpn, input logic [19:0] ppn,
                           input logic [3:0] sz, input logic [3:0] pm);
    @(negedge clk);
    fill_block = 1'b1; fill_blk_idx = idx; fill_vpn = vpn; fill_ppn = ppn;
    fill_size = sz; fill_perm = pm;
    @(negedge clk);
    fill_block = 1'b0;
  endtask

  task automatic do_purge();
    @(negedge clk);
    purge = 1'b1;
    @(negedge clk);
    purge = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1 outputs quiet while reset is held
    check(!res_valid && !res_hit && !res_miss && res_paddr == 0, "R1",
          {res_valid, res_hit, res_miss, res_paddr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid && !res_hit && !res_miss, "R1", {res_valid, res_hit, res_miss}, 0);
    expect_miss(48'h0000_0000_0000, "R1");
    expect_miss(48'h1234_5678_9ABC, "R1");
  endtask

  task automatic t_page();
    put_page(36'h0_0004_2000, 20'h1_2345, 4'h5);
    expect_hit({36'h0_0004_2000, 12'h000}, {20'h1_2345, 12'h000}, 4'h5, "R3");
    expect_hit({36'h0_0004_2000, 12'hFFF}, {20'h1_2345, 12'hFFF}, 4'h5, "R3");
    expect_hit({36'h0_0004_2000, 12'h5A3}, {20'h1_2345, 12'h5A3}, 4'h5, "R3");
    expect_miss({36'h0_0004_2001, 12'h5A3}, "R4");
    expect_miss({36'h8_0004_2000, 12'h000}, "R4");
    // R2 idle cycle after a lookup
    @(negedge clk);
    check(!res_valid && !res_hit && !res_miss, "R2", {res_valid, res_hit, res_miss}, 0);
  endtask

  task automatic t_block();
    // base with stray bits below alignment, size code 8 (1 MB)
    put_block(2'd1, 36'h0_0012_34FF, 20'hA_BCFF, 4'd8, 4'h3);
    expect_hit({36'h0_0012_34A7, 12'h3C5}, exp_blk(36'h0_0012_34A7, 12'h3C5, 20'hA_BCFF, 8), 4'h3, "R5");
    expect_hit({36'h0_0012_3400, 12'h000}, exp_blk(36'h0_0012_3400, 12'h000, 20'hA_BCFF, 8), 4'h3, "R5");
    expect_miss({36'h0_0012_3500, 12'h000}, "R5");
    expect_miss({36'h0_0012_33FF, 12'hFFF}, "R5");
    // size code 0: single page
    put_block(2'd0, 36'h0_0000_0777, 20'h0_BEEF, 4'd0, 4'h1);
    expect_hit({36'h0_0000_0777, 12'h010}, {20'h0_BEEF, 12'h010}, 4'h1, "R5");
    expect_miss({36'h0_0000_0778, 12'h010}, "R5");
    // size code 12: 16 MB
    put_block(2'd2, 36'h0_00A0_0000, 20'h5_5000, 4'd12, 4'h7);
    expect_hit({36'h0_00A0_0FFF, 12'h123}, exp_blk(36'h0_00A0_0FFF, 12'h123, 20'h5_5000, 12), 4'h7, "R5");
    expect_miss({36'h0_00A0_1000, 12'h000}, "R5");
    // R11 oversized code behaves as 16 MB
    put_block(2'd3, 36'h0_00B0_0000, 20'h6_6000, 4'd15, 4'h9);
    expect_hit({36'h0_00B0_0FFF, 12'h001}, {20'h6_6FFF, 12'h001}, 4'h9, "R11");
    expect_miss({36'h0_00B0_1000, 12'h000}, "R11");
  endtask

  task automatic t_prio();
    put_page(36'h0_0012_3410, 20'h1_1111, 4'hE);
    // R6 block entry 1 covers this page too
    expect_hit({36'h0_0012_3410, 12'h0AB}, exp_blk(36'h0_0012_3410, 12'h0AB, 20'hA_BCFF, 8), 4'h3, "R6");
  endtask

  task automatic t_rewrite();
    put_block(2'd1, 36'h0_0300_0000, 20'h3_0000, 4'd4, 4'h2);
    expect_miss({36'h0_0012_34A7, 12'h3C5}, "R7");
    // R7 page under the old region shows through now
    expect_hit({36'h0_0012_3410, 12'h0AB}, {20'h1_1111, 12'h0AB}, 4'hE, "R7");
    expect_hit({36'h0_0300_0005, 12'h444}, {20'h3_0005, 12'h444}, 4'h2, "R7");
    expect_hit({36'h0_00A0_0ABC, 12'h000}, exp_blk(36'h0_00A0_0ABC, 12'h000, 20'h5_5000, 12), 4'h7, "R7");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_page = 1'b1; fill_vpn = 36'h0_0777_0000; fill_ppn = 20'h7_7777; fill_perm = 4'h6;
    lk_valid = 1'b1; lk_vaddr = {36'h0_0777_0000, 12'h100};
    @(negedge clk);
    fill_page = 1'b0; lk_valid = 1'b0;
    // R10 lookup saw the old contents
    check(res_miss && !res_hit, "R10", {res_hit, res_miss}, 2'b01);
    expect_hit({36'h0_0777_0000, 12'h100}, {20'h7_7777, 12'h100}, 4'h6, "R10");
  endtask

  task automatic t_purge();
    do_purge();
    expect_miss({36'h0_0777_0000, 12'h100}, "R9");
    expect_miss({36'h0_00A0_0000, 12'h000}, "R9");
    expect_miss({36'h0_0000_0777, 12'h000}, "R9");
    // R9 writes in the purge cycle are dropped
    @(negedge clk);
    purge = 1'b1;
    fill_page = 1'b1; fill_vpn = 36'h0_0888_0000; fill_ppn = 20'h8_8888; fill_perm = 4'h1;
    fill_block = 1'b1; fill_blk_idx = 2'd0; fill_size = 4'd2;
    @(negedge clk);
    purge = 1'b0; fill_page = 1'b0; fill_block = 1'b0;
    expect_miss({36'h0_0888_0000, 12'h000}, "R9");
  endtask

  task automatic t_round_robin();
    int bad;
    logic h, m; logic [31:0] pa; logic [3:0] pm;
    do_purge();
    for (int i = 0; i < 96; i++)
      put_page(36'h7_0000_0000 + 36'(i), 20'h4_0000 + 20'(i), 4'(i));
    bad = 0;
    for (int i = 0; i < 96; i++) begin
      lookup({36'h7_0000_0000 + 36'(i), 12'h00C}, h, m, pa, pm);
      if (!(h && pa == {20'h4_0000 + 20'(i), 12'h00C} && pm == 4'(i))) bad++;
    end
    check(bad == 0, "R8", 64'(bad), 0);
    put_page(36'h7_0000_1000, 20'h5_0000, 4'hC);
    expect_miss({36'h7_0000_0000, 12'h000}, "R8");
    expect_hit({36'h7_0000_0001, 12'h000}, {20'h4_0001, 12'h000}, 4'h1, "R8");
    expect_hit({36'h7_0000_1000, 12'h0F0}, {20'h5_0000, 12'h0F0}, 4'hC, "R8");
  endtask

  initial begin
    t_reset();
    t_page();
    t_block();
    t_prio();
    t_rewrite();
    t_same_cycle();
    t_purge();
    t_round_robin();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule